// File: doc/BRIEF.md
# PMP CSR register bank

This block keeps the physical-memory-protection registers of a RISC-V style hart. Each protection entry has an 8-bit configuration byte and an address register. A CSR access port reaches both kinds with a 12-bit CSR number, a read strobe and a write strobe. Configuration bytes are packed several to a CSR word. How many bytes go in a word, and which CSR numbers exist, both depend on XLEN (32 or 64).

Writes are filtered before they are stored:
- Reserved field combinations are cleaned up.
- Locked configuration bytes keep their old value.
- An address register is protected by its own entry's lock.
- An address register is also protected by the following entry's lock when that following entry is in top-of-range mode.

During a write, the data port shows the value that the register will hold after the clock edge, not the raw write data. CSR numbers outside the protection map raise an illegal-access flag.

Top module: `pmp_csr_bank`

## Requirements
- R1: CSR numbers 0x3A0..0x3AF select configuration words. With XLEN=32 all sixteen are valid. With XLEN=64, odd numbers are illegal and only even numbers are valid.
- R2: CSR numbers 0x3B0..0x3EF select address registers. The entry index is {csr_addr[7:4]-4'hB (2 bits), csr_addr[3:0]}, so 0x3B0 is entry 0, 0x3BF is entry 15 and 0x3C5 is entry 21.
- R3: Configuration word k holds the bytes of entries 4k and upward, lowest entry in byte 0. There are 4 bytes per word with XLEN=32 and 8 bytes per even word with XLEN=64. Byte layout: bit0 read, bit1 write, bit2 execute, bits4:3 mode (00 off, 01 top-of-range, 10 4-byte aligned, 11 power-of-two aligned), bits6:5 always read 0, bit7 lock.
- R4: A written byte with write=1 and read=0 is stored with write forced to 0.
- R5: A configuration byte whose lock bit is set keeps its value on writes, while unlocked bytes of the same word take the new data. A lock bit is cleared only by reset.
- R6: A write to address register N has no effect while configuration entry N is locked.
- R7: A write to address register N has no effect while entry N+1 is locked with mode 01. A lock on entry N+1 with any other mode does not block it.
- R8: The highest implemented entry checks only its own lock.
- R9: While csr_wr is high, csr_rdata shows the register's contents after the write, including kept locked fields.
- R10: Entries at or above NUM_ENTRIES read as zero and ignore writes. Their CSR numbers are still legal.
- R11: An access (csr_rd or csr_wr) to a CSR number outside R1/R2 raises csr_illegal in that cycle with csr_rdata zero. csr_illegal is low when there is no access.
- R12: Reset clears all registers to zero. Reads are combinational and writes take effect at the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | CSR number of the access |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Readback value (post-write value during a write) |
| csr_illegal | output | 1 | Access to a CSR number outside the protection map |

## Verification
The bench builds two instances. The first has XLEN=32 with 16 entries. It covers four-byte packing, every lock interaction on address writes, the top-of-range chain across neighbouring entries, and entries above 15 that read as zero. The second has XLEN=64 with 8 entries. It covers odd configuration numbers being illegal, eight-byte packing that reaches entry 7 in the top byte, a configuration word whose entries are all unimplemented, and a highest entry whose neighbour does not exist.

// File: rtl/pmp_csr_pkg.sv
package pmp_csr_pkg;

    typedef struct packed {
        logic       lock;
        logic [1:0] rsvd;
        logic [1:0] mode;
        logic       x;
        logic       w;
        logic       r;
    } pmp_cfg_t;

    localparam logic [1:0] MODE_OFF = 2'b00;
    localparam logic [1:0] MODE_TOR = 2'b01;

    localparam logic [7:0] CFG_PAGE = 8'h3A;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_ADDR = 2'd2
    } csr_sel_e;

endpackage

// File: rtl/pmp_csr_decode.sv
module pmp_csr_decode
    import pmp_csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [11:0] csr_addr,
    input  logic        access,
    output csr_sel_e    sel,
    output logic [3:0]  cfg_reg,
    output logic [5:0]  entry_idx,
    output logic        illegal
);

    always_comb begin
        sel = SEL_NONE;
        if (csr_addr[11:4] == CFG_PAGE) begin
            if (!((XLEN == 64) && csr_addr[0])) begin
                sel = SEL_CFG;
            end
        end else if ((csr_addr[11:8] == 4'h3) &&
                     (csr_addr[7:4] >= 4'hB) && (csr_addr[7:4] <= 4'hE)) begin
            sel = SEL_ADDR;
        end
    end

    assign cfg_reg   = csr_addr[3:0];
    // pages B,C,D,E map to index bits 00,01,10,11
    assign entry_idx = {csr_addr[5:4] + 2'b01, csr_addr[3:0]};
    assign illegal   = access && (sel == SEL_NONE);

endmodule

// File: rtl/pmp_cfg_lane.sv
module pmp_cfg_lane
    import pmp_csr_pkg::*;
(
    input  pmp_cfg_t   old_cfg,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    output pmp_cfg_t   new_cfg
);

    pmp_cfg_t cand;

    always_comb begin
        cand = pmp_cfg_t'(wr_byte & 8'h9F);
        if (cand.w && !cand.r) begin
            cand.w = 1'b0;
        end
        new_cfg = (wr_en && !old_cfg.lock) ? cand : old_cfg;
    end

endmodule

// File: rtl/pmp_addr_lane.sv
module pmp_addr_lane
    import pmp_csr_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int HAS_NEXT = 1
) (
    input  logic [XLEN-1:0] old_addr,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic            own_lock,
    input  logic            next_lock,
    input  logic [1:0]      next_mode,
    output logic [XLEN-1:0] new_addr
);

    logic blocked;

    always_comb begin
        blocked = own_lock;
        if (HAS_NEXT != 0) begin
            blocked = blocked | (next_lock && (next_mode == MODE_TOR));
        end
        new_addr = (wr_en && !blocked) ? wr_data : old_addr;
    end

endmodule

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
    import pmp_csr_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int NUM_ENTRIES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     csr_addr,
    input  logic            csr_rd,
    input  logic            csr_wr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_illegal
);

    localparam int BYTES_PER_REG = XLEN / 8;
    localparam int REG_STRIDE    = BYTES_PER_REG / 4;
    localparam int IDX_W         = 6;

    typedef struct packed {
        pmp_cfg_t [NUM_ENTRIES-1:0]            cfg;
        logic     [NUM_ENTRIES-1:0][XLEN-1:0]  addr;
    } bank_t;

    bank_t st_d, st_q;

    csr_sel_e             sel;
    logic [3:0]           cfg_reg;
    logic [IDX_W-1:0]     entry_idx;
    logic                 access;

    pmp_cfg_t [NUM_ENTRIES-1:0]           cfg_nx;
    logic     [NUM_ENTRIES-1:0][XLEN-1:0] addr_nx;

    logic [NUM_ENTRIES*8-1:0]    cfg_view;
    logic [NUM_ENTRIES*XLEN-1:0] addr_view;

    assign access = csr_rd | csr_wr;

    pmp_csr_decode #(.XLEN(XLEN)) u_dec (
        .csr_addr  (csr_addr),
        .access    (access),
        .sel       (sel),
        .cfg_reg   (cfg_reg),
        .entry_idx (entry_idx),
        .illegal   (csr_illegal)
    );

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
        localparam int REG_OF  = (e / BYTES_PER_REG) * REG_STRIDE;
        localparam int BYTE_OF = e % BYTES_PER_REG;
        localparam int FOLLOW  = (e < NUM_ENTRIES - 1) ? 1 : 0;

        logic       cfg_we;
        logic       addr_we;
        logic       nxt_lock;
        logic [1:0] nxt_mode;

        assign cfg_we  = csr_wr && (sel == SEL_CFG)  && (cfg_reg == 4'(REG_OF));
        assign addr_we = csr_wr && (sel == SEL_ADDR) && (entry_idx == IDX_W'(e));

        if (FOLLOW != 0) begin : g_follow
            assign nxt_lock = st_q.cfg[e+1].lock;
            assign nxt_mode = st_q.cfg[e+1].mode;
        end else begin : g_last
            assign nxt_lock = 1'b0;
            assign nxt_mode = MODE_OFF;
        end

        pmp_cfg_lane u_cfg (
            .old_cfg (st_q.cfg[e]),
            .wr_en   (cfg_we),
            .wr_byte (csr_wdata[BYTE_OF*8 +: 8]),
            .new_cfg (cfg_nx[e])
        );

        pmp_addr_lane #(.XLEN(XLEN), .HAS_NEXT(FOLLOW)) u_addr (
            .old_addr  (st_q.addr[e]),
            .wr_en     (addr_we),
            .wr_data   (csr_wdata),
            .own_lock  (st_q.cfg[e].lock),
            .next_lock (nxt_lock),
            .next_mode (nxt_mode),
            .new_addr  (addr_nx[e])
        );
    end

    always_comb begin : p_next
        st_d = st_q;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            st_d.cfg[e]  = cfg_nx[e];
            st_d.addr[e] = addr_nx[e];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin : p_state
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // readback is taken from the next state so a write shows its stored result
    always_comb begin : p_read
        csr_rdata = '0;
        if (access) begin
            case (sel)
                SEL_CFG: begin
                    for (int e = 0; e < NUM_ENTRIES; e++) begin
                        if (cfg_reg == 4'((e / BYTES_PER_REG) * REG_STRIDE)) begin
                            csr_rdata[(e % BYTES_PER_REG)*8 +: 8] = st_d.cfg[e];
                        end
                    end
                end
                SEL_ADDR: begin
                    for (int e = 0; e < NUM_ENTRIES; e++) begin
                        if (entry_idx == IDX_W'(e)) begin
                            csr_rdata = st_d.addr[e];
                        end
                    end
                end
                default: csr_rdata = '0;
            endcase
        end
    end

    assign cfg_view  = st_q.cfg;
    assign addr_view = st_q.addr;

endmodule

// File: rtl/pmp_csr_bank_chk.sv
module pmp_csr_bank_chk #(
    parameter int XLEN        = 32,
    parameter int NUM_ENTRIES = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        csr_rd,
    input logic                        csr_wr,
    input logic [XLEN-1:0]             csr_rdata,
    input logic                        csr_illegal,
    input logic [NUM_ENTRIES*8-1:0]    cfg_view,
    input logic [NUM_ENTRIES*XLEN-1:0] addr_view
);

    p_illegal_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> (csr_rdata == '0));

    p_illegal_needs_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> (csr_rd || csr_wr));

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_chk
        p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_view[e*8+7] |=> cfg_view[e*8+7]);

        p_locked_byte_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_view[e*8+7] |=> $stable(cfg_view[e*8 +: 8]));

        p_own_lock_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_view[e*8+7] |=> $stable(addr_view[e*XLEN +: XLEN]));

        p_no_write_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_view[e*8+1] && !cfg_view[e*8]));

        p_zero_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_view[e*8+5 +: 2] == 2'b00);

        if (e < NUM_ENTRIES - 1) begin : g_tor
            p_tor_neighbour_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_view[(e+1)*8+7] && (cfg_view[(e+1)*8+3 +: 2] == 2'b01))
                |=> $stable(addr_view[e*XLEN +: XLEN]));
        end
    end

endmodule

bind pmp_csr_bank pmp_csr_bank_chk #(
    .XLEN        (XLEN),
    .NUM_ENTRIES (NUM_ENTRIES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_rd      (csr_rd),
    .csr_wr      (csr_wr),
    .csr_rdata   (csr_rdata),
    .csr_illegal (csr_illegal),
    .cfg_view    (cfg_view),
    .addr_view   (addr_view)
);

// File: tb/sim_pmp_csr_bank.sv
module sim_pmp_csr_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic        rd0 = 1'b0, wr0 = 1'b0, rd1 = 1'b0, wr1 = 1'b0;
    logic [31:0] rdata0;
    logic [63:0] rdata1;
    logic        ill0, ill1;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pmp_csr_bank #(.XLEN(32), .NUM_ENTRIES(16)) u0 (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_rd(rd0), .csr_wr(wr0),
        .csr_wdata(wdata[31:0]), .csr_rdata(rdata0), .csr_illegal(ill0)
    );

    pmp_csr_bank #(.XLEN(64), .NUM_ENTRIES(8)) u1 (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_rd(rd1), .csr_wr(wr1),
        .csr_wdata(wdata), .csr_rdata(rdata1), .csr_illegal(ill1)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] a;
        logic [31:0] d;
        logic [31:0] exp;
        logic        ill;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 12'h3A0, 32'h0,        32'h0,        1'b0},  // R12 reset value
        '{1'b1, 12'h3A0, 32'h620D0B03, 32'h000D0B03, 1'b0},  // R3 R4 R9 clean-up
        '{1'b0, 12'h3A0, 32'h0,        32'h000D0B03, 1'b0},  // R3 R12 stored
        '{1'b1, 12'h3A1, 32'h07060504, 32'h07040504, 1'b0},  // R3 R4 word 1
        '{1'b1, 12'h3B0, 32'h12345678, 32'h12345678, 1'b0},  // R2 entry 0
        '{1'b1, 12'h3C5, 32'h11111111, 32'h0,        1'b0},  // R2 R10 entry 21
        '{1'b1, 12'h3BF, 32'hCAFEF00D, 32'hCAFEF00D, 1'b0},  // R2 R8 entry 15
        '{1'b0, 12'h3B0, 32'h0,        32'h12345678, 1'b0},  // R2 R12 read
        '{1'b0, 12'h3F0, 32'h0,        32'h0,        1'b1},  // R11 above map
        '{1'b1, 12'h3A5, 32'hFFFFFFFF, 32'h0,        1'b0},  // R1 R10 legal, unimpl
        '{1'b0, 12'h39F, 32'h0,        32'h0,        1'b1},  // R11 below map
        '{1'b0, 12'h3AF, 32'h0,        32'h0,        1'b0}   // R1 last cfg number
    };

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic acc(input int unit, input logic w, input logic [11:0] a,
                       input logic [63:0] d, input logic [63:0] exp,
                       input logic ill_exp, input string tag);
        @(negedge clk);
        addr  = a;
        wdata = d;
        if (unit == 0) begin rd0 = !w; wr0 = w; end
        else           begin rd1 = !w; wr1 = w; end
        #1;
        if (unit == 0) begin
            check({tag, " rdata"}, {32'h0, rdata0}, exp);
            check({tag, " illegal"}, {63'h0, ill0}, {63'h0, ill_exp});
        end else begin
            check({tag, " rdata"}, rdata1, exp);
            check({tag, " illegal"}, {63'h0, ill1}, {63'h0, ill_exp});
        end
        @(posedge clk);
        #1;
        rd0 = 1'b0; wr0 = 1'b0; rd1 = 1'b0; wr1 = 1'b0;
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            acc(0, VEC[i].wr, VEC[i].a, {32'h0, VEC[i].d}, {32'h0, VEC[i].exp},
                VEC[i].ill, $sformatf("table vector %0d", i));
        end

        // entry 1 locked in top-of-range mode
        acc(0, 1, 12'h3A0, 64'h000D8B03, 64'h000D8B03, 0, "R5 set lock entry1");
        acc(0, 1, 12'h3B1, 64'hDEADBEEF, 64'h0,        0, "R6 own lock blocks");
        acc(0, 1, 12'h3B0, 64'h0BADF00D, 64'h12345678, 0, "R7 TOR neighbour blocks");
        acc(0, 1, 12'h3B2, 64'h00002222, 64'h00002222, 0, "R7 unlocked neighbour allows");
        acc(0, 1, 12'h3A0, 64'h11223344, 64'h11008B04, 0, "R5 R9 mixed locked word");
        acc(0, 1, 12'h3A0, 64'h0,        64'h00008B00, 0, "R5 lock not cleared");
        // entry 5 locked in 4-byte aligned mode
        acc(0, 1, 12'h3A1, 64'h07049004, 64'h07049004, 0, "R5 set lock entry5");
        acc(0, 1, 12'h3B4, 64'hAAAA5555, 64'hAAAA5555, 0, "R7 non-TOR neighbour allows");
        acc(0, 1, 12'h3B5, 64'h1,        64'h0,        0, "R6 entry5 blocked");
        // highest entry 15 locked in TOR mode
        acc(0, 1, 12'h3A3, 64'h88000000, 64'h88000000, 0, "R3 set lock entry15");
        acc(0, 1, 12'h3BE, 64'h77,       64'h0,        0, "R7 entry14 blocked");
        acc(0, 1, 12'h3BF, 64'h0,        64'hCAFEF00D, 0, "R8 entry15 own lock");

        #1;
        check("R11 idle illegal low", {63'h0, ill0}, 64'h0);

        // reset clears everything, including locks
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        acc(0, 0, 12'h3A0, 64'h0, 64'h0, 0, "R12 cfg after reset");
        acc(0, 0, 12'h3BF, 64'h0, 64'h0, 0, "R12 addr after reset");
        acc(0, 1, 12'h3B0, 64'h55, 64'h55, 0, "R5 reset released lock");

        // 64-bit instance, 8 entries
        acc(1, 0, 12'h3A1, 64'h0, 64'h0, 1, "R1 odd cfg illegal xlen64");
        acc(1, 1, 12'h3A7, 64'hFF, 64'h0, 1, "R1 R11 odd cfg write xlen64");
        acc(1, 1, 12'h3A0, 64'h0F0E0D0C0B0A0908, 64'h0F0C0D0C0B080908, 0, "R3 R4 eight-byte packing");
        acc(1, 0, 12'h3A0, 64'h0, 64'h0F0C0D0C0B080908, 0, "R3 xlen64 readback");
        acc(1, 1, 12'h3A2, 64'h8888888888888888, 64'h0, 0, "R10 unimplemented cfg word");
        acc(1, 1, 12'h3B7, 64'h0123456789ABCDEF, 64'h0123456789ABCDEF, 0, "R8 highest entry xlen64");
        acc(1, 0, 12'h3B8, 64'h0, 64'h0, 0, "R10 entry8 reads zero");
        acc(1, 1, 12'h3B6, 64'hFEDCBA9876543210, 64'hFEDCBA9876543210, 0, "R2 R9 xlen64 addr write");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule